// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading two table entries from memory. The upper index field picks an entry in a directory table, whose location is given by a 20-bit directory base. That entry names the page holding the second-level table. The middle index field then picks an entry in that second table, and that entry supplies the frame number. The low 12-bit offset is passed through unchanged, so a page is 4 KB.

A client presents one request at a time with a read or write intent. The walker issues at most two reads on a memory port that uses a request/acknowledge handshake of any latency. It checks the valid and writable bits of the entries it reads. It then reports, for one cycle, either a physical address or a fault code. A directory entry that is not valid stops the walk after the first read.

Top module: `pgw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req` and `done_valid` are 0.
- R2: The first read uses address `{dir_base, 12'b0} + 4*vaddr[31:22]`, with `dir_base` sampled when the request is accepted.
- R3: The second read uses address `{dentry[31:12], 12'b0} + 4*vaddr[21:12]`, where `dentry` is the word returned by the first read.
- R4: A walk that succeeds reports `done_code` = 0 and `done_paddr = {pentry[31:12], vaddr[11:0]}`, where `pentry` is the word returned by the second read.
- R5: If bit 0 (valid) of the directory entry is 0, the walk reports `done_code` = 1 after exactly one memory read.
- R6: If bit 0 of the second-level entry is 0, the walk reports `done_code` = 2 after two reads.
- R7: A write request whose second-level entry has bit 1 (writable) equal to 0 reports `done_code` = 3. A read request to that same entry succeeds. Bit 1 of the directory entry has no effect on the result.
- R8: Once `mem_req` is raised, it stays high and `mem_addr` stays unchanged until the cycle in which `mem_ack` is sampled high. The walk works with any acknowledge latency, including an acknowledge in the first cycle.
- R9: `done_valid` is high for exactly one cycle, and `req_ready` is high again in the cycle after it. Request inputs that change while a walk is in progress do not affect that walk.
- R10: Whenever a fault code is reported, `done_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| dir_base | input | 20 | Page number of the directory table |
| req_ready | output | 1 | Walker idle; a request is accepted this cycle |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the table entry to read |
| mem_ack | input | 1 | Read data valid, ends the current read |
| mem_rdata | input | 32 | Entry word returned by memory |
| done_valid | output | 1 | One-cycle result strobe |
| done_code | output | 2 | 0 ok, 1 directory invalid, 2 page entry invalid, 3 write protect |
| done_paddr | output | 32 | Physical address; 0 on a fault |

## Verification
The bench builds the walker with its default parameters: a 10/10/12 split, 32-bit entries and a 20-bit frame. With these values the entry index plus its 2-bit byte shift fills the 12-bit offset exactly, so the concatenating address variant is the one checked. Its memory model returns chosen entry words and varies the acknowledge latency from zero to several cycles. This covers each fault path, the single-read early exit, and unchanged request hold across waits. Random walks with a fixed seed mix valid and writable bits at both levels, including a second-level table that overlaps the directory page.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_OUTER = 2'd1,
      FLT_INNER = 2'd2,
      FLT_PROT  = 2'd3
   } pgw_fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_OUTER,
      ST_RD_INNER,
      ST_DONE,
      ST_FAULT
   } pgw_state_e;

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
   parameter int PA_W   = 32,
   parameter int BASE_W = 20,
   parameter int IDX_W  = 10,
   parameter int ENT_W  = 32
) (
   input  logic [BASE_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [PA_W-1:0]   addr
);
   localparam int OFF_W  = PA_W - BASE_W;
   localparam int ENT_SH = $clog2(ENT_W / 8);
   localparam int PAD_W  = OFF_W - IDX_W - ENT_SH;

   if (ENT_W % 8 != 0) begin : g_bad_ent
      $error("pgw_addr_gen: ENT_W must be a whole number of bytes");
   end

   if (PAD_W > 0) begin : g_pad
      assign addr = {base, {PAD_W{1'b0}}, idx, {ENT_SH{1'b0}}};
   end else if (PAD_W == 0 && ENT_SH > 0) begin : g_exact
      assign addr = {base, idx, {ENT_SH{1'b0}}};
   end else if (PAD_W == 0) begin : g_exact_byte
      assign addr = {base, idx};
   end else begin : g_add
      logic [PA_W-1:0] base_ext;
      logic [PA_W-1:0] idx_ext;
      assign base_ext = {base, {OFF_W{1'b0}}};
      assign idx_ext  = PA_W'(idx) << ENT_SH;
      assign addr     = base_ext + idx_ext;
   end

endmodule

// File: rtl/pgw_entry_check.sv
module pgw_entry_check
   import pgw_pkg::*;
#(
   parameter int ENT_W     = 32,
   parameter int FRAME_W   = 20,
   parameter int VALID_BIT = 0,
   parameter int WRITE_BIT = 1
) (
   input  logic [ENT_W-1:0]   entry,
   input  logic               inner_lvl,
   input  logic               wr_req,
   output logic [FRAME_W-1:0] frame,
   output pgw_fault_e         fault
);
   if (VALID_BIT >= ENT_W - FRAME_W || WRITE_BIT >= ENT_W - FRAME_W
       || VALID_BIT == WRITE_BIT) begin : g_bad_bits
      $error("pgw_entry_check: attribute bits must be distinct and below the frame field");
   end

   logic ent_valid;
   logic ent_wr;

   assign frame     = entry[ENT_W-1 -: FRAME_W];
   assign ent_valid = entry[VALID_BIT];
   assign ent_wr    = entry[WRITE_BIT];

   always_comb begin
      if (!ent_valid)
         fault = inner_lvl ? FLT_INNER : FLT_OUTER;
      else if (inner_lvl && wr_req && !ent_wr)
         fault = FLT_PROT;
      else
         fault = FLT_NONE;
   end

   always_comb begin
      a_prot_needs_write_r7 : assert (fault != FLT_PROT || (wr_req && inner_lvl));
   end

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
   import pgw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       mem_ack,
   input  pgw_fault_e fault,
   output pgw_state_e state
);
   pgw_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:     if (start) state_nx = ST_RD_OUTER;
         ST_RD_OUTER: if (mem_ack) state_nx = (fault != FLT_NONE) ? ST_FAULT : ST_RD_INNER;
         ST_RD_INNER: if (mem_ack) state_nx = (fault != FLT_NONE) ? ST_FAULT : ST_DONE;
         ST_DONE:     state_nx = ST_IDLE;
         ST_FAULT:    state_nx = ST_IDLE;
         default:     state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   p_outer_stop_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_OUTER && mem_ack && fault == FLT_OUTER) |=> (state == ST_FAULT));

   p_wait_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_INNER && !mem_ack) |=> (state == ST_RD_INNER));

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int OUTER_W   = 10,
   parameter int INNER_W   = 10,
   parameter int ENT_W     = 32,
   parameter int FRAME_W   = 20,
   parameter int VALID_BIT = 0,
   parameter int WRITE_BIT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic               req_write,
   input  logic [FRAME_W-1:0] dir_base,
   output logic               req_ready,
   output logic               mem_req,
   output logic [FRAME_W+VA_W-OUTER_W-INNER_W-1:0] mem_addr,
   input  logic               mem_ack,
   input  logic [ENT_W-1:0]   mem_rdata,
   output logic               done_valid,
   output logic [1:0]         done_code,
   output logic [FRAME_W+VA_W-OUTER_W-INNER_W-1:0] done_paddr
);
   localparam int OFF_W = VA_W - OUTER_W - INNER_W;
   localparam int PA_W  = FRAME_W + OFF_W;

   if (OFF_W <= 0) begin : g_bad_split
      $error("pgw_walker: index fields leave no page offset");
   end
   if (ENT_W < FRAME_W + 2) begin : g_bad_entry
      $error("pgw_walker: entry too narrow for frame plus attributes");
   end

   pgw_state_e state;
   pgw_fault_e fault;
   logic [FRAME_W-1:0] frame;
   logic               start;

   logic [VA_W-1:0]    va_q;
   logic               wr_q;
   logic [FRAME_W-1:0] dir_q;
   logic [FRAME_W-1:0] tbl_q;
   logic [FRAME_W-1:0] frame_q;
   pgw_fault_e         code_q;

   logic [FRAME_W-1:0] sel_base;
   logic [OUTER_W-1:0] idx_outer;
   logic [INNER_W-1:0] idx_inner;
   logic [OFF_W-1:0]   page_off;
   logic [PA_W-1:0]    addr_outer;
   logic [PA_W-1:0]    addr_inner;
   logic               inner_lvl;

   assign start     = (state == ST_IDLE) && req_valid;
   assign inner_lvl = (state == ST_RD_INNER);
   assign idx_outer = va_q[VA_W-1 -: OUTER_W];
   assign idx_inner = va_q[OFF_W +: INNER_W];
   assign page_off  = va_q[OFF_W-1:0];
   assign sel_base  = tbl_q;

   pgw_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mem_ack (mem_ack),
      .fault   (fault),
      .state   (state)
   );

   pgw_addr_gen #(
      .PA_W   (PA_W),
      .BASE_W (FRAME_W),
      .IDX_W  (OUTER_W),
      .ENT_W  (ENT_W)
   ) u_addr_outer (
      .base (dir_q),
      .idx  (idx_outer),
      .addr (addr_outer)
   );

   pgw_addr_gen #(
      .PA_W   (PA_W),
      .BASE_W (FRAME_W),
      .IDX_W  (INNER_W),
      .ENT_W  (ENT_W)
   ) u_addr_inner (
      .base (sel_base),
      .idx  (idx_inner),
      .addr (addr_inner)
   );

   pgw_entry_check #(
      .ENT_W     (ENT_W),
      .FRAME_W   (FRAME_W),
      .VALID_BIT (VALID_BIT),
      .WRITE_BIT (WRITE_BIT)
   ) u_check (
      .entry     (mem_rdata),
      .inner_lvl (inner_lvl),
      .wr_req    (wr_q),
      .frame     (frame),
      .fault     (fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q    <= '0;
         wr_q    <= 1'b0;
         dir_q   <= '0;
         tbl_q   <= '0;
         frame_q <= '0;
         code_q  <= FLT_NONE;
      end else begin
         if (start) begin
            va_q   <= req_vaddr;
            wr_q   <= req_write;
            dir_q  <= dir_base;
            code_q <= FLT_NONE;
         end
         if (mem_ack && (state == ST_RD_OUTER || state == ST_RD_INNER)) begin
            if (fault != FLT_NONE)
               code_q <= fault;
            else if (state == ST_RD_OUTER)
               tbl_q <= frame;
            else
               frame_q <= frame;
         end
      end
   end

   assign req_ready  = (state == ST_IDLE);
   assign mem_req    = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
   assign mem_addr   = inner_lvl ? addr_inner : addr_outer;
   assign done_valid = (state == ST_DONE) || (state == ST_FAULT);
   assign done_code  = code_q;
   assign done_paddr = (state == ST_DONE) ? {frame_q, page_off} : '0;

   p_reset_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   p_req_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   p_entry_align_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   p_done_pulse_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

   p_fault_zero_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_code != 2'd0) |-> (done_paddr == '0));

   p_done_after_read_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_valid) |-> $past(mem_req && mem_ack));

endmodule

// File: tb/pgw_walker_bench.sv
module pgw_walker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic [19:0] dir_base = '0;
   logic        req_ready;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done_valid;
   logic [1:0]  done_code;
   logic [31:0] done_paddr;

   int checks = 0;
   int failures = 0;

   // memory model state
   logic [31:0] m_oe, m_ie, m_a0, m_a1;
   int          m_lat_max = 0;
   int          m_reads = 0;
   int          m_addr_err = 0;
   int          wait_cnt = 0;
   int          cur_lat = 0;

   always #5 clk = ~clk;

   pgw_walker u_pgw_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_vaddr  (req_vaddr),
      .req_write  (req_write),
      .dir_base   (dir_base),
      .req_ready  (req_ready),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .done_valid (done_valid),
      .done_code  (done_code),
      .done_paddr (done_paddr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // memory responder: acknowledges after a random number of waits
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (wait_cnt >= cur_lat) begin
               if (m_reads == 0 && mem_addr != m_a0) m_addr_err++;
               if (m_reads == 1 && mem_addr != m_a1) m_addr_err++;
               mem_rdata = (m_reads == 0) ? m_oe : m_ie;
               mem_ack   = 1'b1;
               m_reads++;
               wait_cnt  = 0;
               cur_lat   = $urandom_range(m_lat_max, 0);
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   function automatic logic [1:0] exp_code(input logic [31:0] va, input bit wr,
                                           input logic [31:0] oe, input logic [31:0] ie);
      if (!oe[0]) return 2'd1;
      if (!ie[0]) return 2'd2;
      if (wr && !ie[1]) return 2'd3;
      return 2'd0;
   endfunction

   task automatic walk(input logic [31:0] va, input bit wr, input logic [19:0] db,
                       input logic [31:0] oe, input logic [31:0] ie, input int lat,
                       input string tag);
      logic [1:0]  ec;
      logic [31:0] ep;
      int          tmo;
      ec = exp_code(va, wr, oe, ie);
      ep = (ec == 2'd0) ? {ie[31:12], va[11:0]} : 32'h0;
      m_oe = oe; m_ie = ie;
      m_a0 = {db, 12'b0} + {20'b0, va[31:22], 2'b00};
      m_a1 = {oe[31:12], 12'b0} + {20'b0, va[21:12], 2'b00};
      m_lat_max = lat; m_reads = 0; m_addr_err = 0; wait_cnt = 0;
      cur_lat = $urandom_range(lat, 0);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; dir_base = db;
      @(negedge clk);
      // R9: disturb inputs while the walk runs
      req_valid = 1'b0; req_vaddr = $urandom; req_write = ~wr; dir_base = $urandom;
      tmo = 0;
      while (!done_valid && tmo < 100) begin
         @(negedge clk);
         tmo++;
      end
      chk(done_valid, "R9", {tag, " done seen"}, 32'(done_valid), 32'd1);
      chk(done_code == ec, (ec == 2'd1) ? "R5" : (ec == 2'd2) ? "R6" : (ec == 2'd3) ? "R7" : "R4",
          {tag, " code"}, 32'(done_code), 32'(ec));
      chk(done_paddr == ep, (ec == 2'd0) ? "R4" : "R10", {tag, " paddr"}, done_paddr, ep);
      chk(m_reads == ((ec == 2'd1) ? 1 : 2), "R5", {tag, " read count"},
          32'(m_reads), (ec == 2'd1) ? 32'd1 : 32'd2);
      chk(m_addr_err == 0, "R2", {tag, " table addresses (R3)"}, 32'(m_addr_err), 32'd0);
      @(negedge clk);
      chk(!done_valid && req_ready, "R9", {tag, " pulse end"},
          {30'b0, done_valid, req_ready}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready && !mem_req && !done_valid, "R1", "reset outputs",
          {29'b0, req_ready, mem_req, done_valid}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !mem_req && !done_valid, "R1", "idle after reset",
          {29'b0, req_ready, mem_req, done_valid}, 32'd4);

      // R4 plain read success, zero latency
      walk(32'h1234_5678, 1'b0, 20'h0_0100, 32'h0020_0001, 32'hABCD_E003, 0, "R4 read");
      // R8 long latency
      walk(32'hFFFF_FFFF, 1'b1, 20'hF_FFFF, 32'h0000_1003, 32'h1111_1003, 6, "R8 slow");
      // R5 directory invalid
      walk(32'h8000_0123, 1'b0, 20'h0_0200, 32'h0030_0002, 32'h5555_5003, 2, "R5 outer");
      // R6 second level invalid
      walk(32'h0040_1FFF, 1'b0, 20'h0_0300, 32'h0040_0001, 32'h7777_7002, 1, "R6 inner");
      // R7 write to read-only page, then read the same page
      walk(32'h0000_0ABC, 1'b1, 20'h0_0400, 32'h0050_0003, 32'h9999_9001, 0, "R7 prot");
      walk(32'h0000_0ABC, 1'b0, 20'h0_0400, 32'h0050_0003, 32'h9999_9001, 0, "R7 ro read");
      // R7 directory writable bit clear does not block a write
      walk(32'h1357_9BDF, 1'b1, 20'h0_0500, 32'h0060_0001, 32'h2468_A003, 3, "R7 outer ro");
      // R3 second table on the directory page
      walk(32'h0010_0004, 1'b0, 20'h0_0700, 32'h0070_0001, 32'h0070_0001, 0, "R3 overlap");

      // random walks
      for (int i = 0; i < 300; i++) begin
         logic [31:0] va, oe, ie;
         logic [19:0] db;
         va = $urandom; db = 20'($urandom);
         oe = $urandom; ie = $urandom;
         oe[0] = ($urandom_range(9, 0) != 0);
         ie[0] = ($urandom_range(9, 0) != 0);
         walk(va, 1'($urandom), db, oe, ie, $urandom_range(4, 0), "R4 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule